// File: doc/BRIEF.md
# Sequential Restoring Divider with Mux Restore

This block divides an unsigned 16-bit dividend, held in a register pair that doubles as the quotient register, by an unsigned 8-bit divisor taken from the accumulator. It is one stage of a small processor datapath. A single start request captures both operands. The block then runs one quotient bit per clock, so a full division takes sixteen steps. In each step the partial remainder is shifted left, and the top bit of the register pair is appended at its bottom. That value goes to one adder together with the stored negated divisor. The adder's carry-out is the quotient bit. The same carry also steers a 2:1 mux that picks either the difference or the unchanged shifted value, so a failed trial never costs an add-back cycle.

The divisor is negated when the operation starts. The carry out of that negation is set exactly when the divisor is zero, and this carry serves as the divide-overflow flag. A zero divisor stops the operation before any step runs. While the steps are running, a quotient strobe is high and the result output shows the register pair. After the last step, a remainder strobe is high for one cycle and the result output carries the remainder. When that strobe ends, the zero flag takes its value from the remainder.

Top module: `restoring_divider`

## Requirements
- R1: After reset, the quotient strobe, remainder strobe, overflow flag, zero flag, register pair and result output are all zero.
- R2: A start request while both strobes are low, with a non-zero accumulator, clears the overflow flag, loads the dividend into the register pair, and raises the quotient strobe on the next clock.
- R3: A start request while idle with a zero accumulator sets the overflow flag on the next clock. No strobe follows, and the register pair and zero flag keep their values.
- R4: The quotient strobe stays high for exactly 16 consecutive cycles per division.
- R5: The remainder strobe is high for exactly one cycle, and it rises on the same edge at which the quotient strobe falls.
- R6: When the remainder strobe is high, the register pair holds floor(dividend / divisor). This holds for every divisor from 1 to 255, including divisors with bit 7 set.
- R7: While the remainder strobe is high, result bits 7:0 equal dividend mod divisor and result bits 15:8 are zero.
- R8: Whenever the remainder strobe is low, the result output equals the register pair.
- R9: On the clock that ends the remainder strobe, the zero flag becomes 1 if the remainder is 0 and 0 otherwise. At no other time does it change.
- R10: A start request is ignored while either strobe is high. Operands and results are not disturbed.
- R11: The overflow flag changes only on a start request that is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a division |
| acc_i | input | 8 | Divisor (accumulator value) |
| dividend_i | input | 16 | Dividend loaded into the register pair |
| pair_o | output | 16 | Register pair; holds the quotient when finished |
| result_o | output | 16 | Pair while not in the remainder cycle, else zero-extended remainder |
| dvoe_o | output | 1 | Quotient strobe, high during the 16 steps |
| rmoe_o | output | 1 | One-cycle remainder strobe |
| ovf_o | output | 1 | Divide-overflow flag (divisor was zero) |
| zero_o | output | 1 | Zero flag taken from the remainder |

## Verification
The sweep runs every divisor from 1 to 255 against sixteen dividends. Those dividends are zero, all ones, a lone top bit, and pseudo-random values. Divisors above 127 test the ninth adder bit: dropping that bit gives wrong quotients only for those divisors. Dividends smaller than the divisor, and those that divide evenly, exercise both values of the zero flag. Start requests injected in the middle of a run and during the remainder cycle confirm that operands are not reloaded. A zero divisor shows the overflow path, and it must not be confused with a normal short division.

// File: rtl/div_pkg.sv
// Shared constants and types for the restoring divider.
// Assumes the divisor width is a power of two so the step counter wraps cleanly.
package div_pkg;
    localparam int unsigned DIVISOR_W_DEF = 8;

    // Selects what appears on the shared result output.
    typedef enum logic {
        RES_PAIR = 1'b0,
        RES_REM  = 1'b1
    } res_sel_e;
endpackage

// File: rtl/div_negate.sv
// Two's-complement negation of the divisor.
// The carry out of the +1 incrementer is 1 only for a zero input, which
// flags a divide by zero. Purely combinational.
module div_negate #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] value_i,
    output logic [DW-1:0] neg_o,
    output logic          carry_o
);
    logic [DW:0] full;

    // Invert, then increment; keep the carry out.
    always_comb begin
        full    = {1'b0, ~value_i} + {{DW{1'b0}}, 1'b1};
        neg_o   = full[DW-1:0];
        carry_o = full[DW];
    end
endmodule

// File: rtl/div_step.sv
// One restoring-division step without add-back.
// The shifted partial remainder is one bit wider than the divisor. It is
// added to the negated divisor, sign-extended to that width with a leading 1.
// The carry out means shifted >= divisor: it is the quotient bit, and it
// selects the difference. Otherwise the shifted value passes unchanged.
// Assumes rem_i < divisor and a non-zero divisor.
module div_step #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] rem_i,
    input  logic          in_bit_i,
    input  logic [DW-1:0] ndiv_i,
    output logic [DW-1:0] rem_o,
    output logic          qbit_o
);
    logic [DW:0]   shifted;
    logic [DW+1:0] sum;

    // Trial subtraction and restoring mux.
    always_comb begin
        shifted = {rem_i, in_bit_i};
        sum     = {1'b0, shifted} + {1'b0, 1'b1, ndiv_i};
        qbit_o  = sum[DW+1];
        rem_o   = qbit_o ? sum[DW-1:0] : shifted[DW-1:0];
    end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: accepts start requests when idle, runs the step counter, and
// produces the quotient and remainder strobes.
// Assumes QW is a power of two, so loading all ones gives QW steps.
module div_ctrl #(
    parameter int unsigned QW = 16,
    localparam int unsigned CW = $clog2(QW)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dvsr_zero_i,
    output logic accept_o,
    output logic go_o,
    output logic dvoe_o,
    output logic rmoe_o
);
    logic [CW-1:0] cnt_q;
    logic          dvoe_q;
    logic          rmoe_q;

    // A request counts only while neither strobe is high.
    always_comb begin
        accept_o = start_i & ~dvoe_q & ~rmoe_q;
        go_o     = accept_o & ~dvsr_zero_i;
    end

    // Step counter and quotient strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dvoe_q <= 1'b0;
        end else if (go_o) begin
            cnt_q  <= '1;
            dvoe_q <= 1'b1;
        end else if (dvoe_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == '0) begin
                dvoe_q <= 1'b0;
            end
        end
    end

    // One-cycle remainder strobe, raised as the quotient strobe drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmoe_q <= 1'b0;
        end else begin
            rmoe_q <= dvoe_q & (cnt_q == '0);
        end
    end

    assign dvoe_o = dvoe_q;
    assign rmoe_o = rmoe_q;
endmodule

// File: rtl/div_datapath.sv
// Operand and result registers: negated divisor, partial remainder, and the
// register pair that shifts left while quotient bits enter at bit 0.
// Assumes load_i and step_i are never high together.
module div_datapath #(
    parameter int unsigned DW = 8,
    localparam int unsigned QW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [DW-1:0] ndiv_i,
    input  logic [QW-1:0] dividend_i,
    output logic [QW-1:0] pair_o,
    output logic [DW-1:0] rem_o
);
    logic [DW-1:0] ndiv_q;
    logic [DW-1:0] rem_q;
    logic [QW-1:0] pair_q;
    logic [DW-1:0] rem_next;
    logic          qbit;

    div_step #(.DW(DW)) u_step (
        .rem_i   (rem_q),
        .in_bit_i(pair_q[QW-1]),
        .ndiv_i  (ndiv_q),
        .rem_o   (rem_next),
        .qbit_o  (qbit)
    );

    // Capture operands on load; shift one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ndiv_q <= '0;
            rem_q  <= '0;
            pair_q <= '0;
        end else if (load_i) begin
            ndiv_q <= ndiv_i;
            rem_q  <= '0;
            pair_q <= dividend_i;
        end else if (step_i) begin
            rem_q  <= rem_next;
            pair_q <= {pair_q[QW-2:0], qbit};
        end
    end

    assign pair_o = pair_q;
    assign rem_o  = rem_q;
endmodule

// File: rtl/div_flags.sv
// Flags: overflow is written on every accepted request; zero is written from
// the remainder at the end of the remainder strobe.
module div_flags #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept_i,
    input  logic          dvsr_zero_i,
    input  logic          rmoe_i,
    input  logic [DW-1:0] rem_i,
    output logic          ovf_o,
    output logic          zero_o
);
    // Overflow flag from the negation carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
        end else if (accept_i) begin
            ovf_o <= dvsr_zero_i;
        end
    end

    // Zero flag from the final remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_o <= 1'b0;
        end else if (rmoe_i) begin
            zero_o <= (rem_i == '0);
        end
    end
endmodule

// File: rtl/restoring_divider.sv
// Top level of the sequential unsigned divider: 2*DW-bit dividend, DW-bit
// divisor, one quotient bit per clock, mux restore instead of add-back.
// Quotient and remainder share one result output, selected by the strobes.
// Assumes DW is a power of two.
module restoring_divider
    import div_pkg::*;
#(
    parameter int unsigned DW = DIVISOR_W_DEF,
    localparam int unsigned QW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] acc_i,
    input  logic [QW-1:0] dividend_i,
    output logic [QW-1:0] pair_o,
    output logic [QW-1:0] result_o,
    output logic          dvoe_o,
    output logic          rmoe_o,
    output logic          ovf_o,
    output logic          zero_o
);
    logic [DW-1:0] ndiv;
    logic          dvsr_zero;
    logic          accept;
    logic          go;
    logic [DW-1:0] rem;
    res_sel_e      sel;

    div_negate #(.DW(DW)) u_neg (
        .value_i(acc_i),
        .neg_o  (ndiv),
        .carry_o(dvsr_zero)
    );

    div_ctrl #(.QW(QW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dvsr_zero_i(dvsr_zero),
        .accept_o   (accept),
        .go_o       (go),
        .dvoe_o     (dvoe_o),
        .rmoe_o     (rmoe_o)
    );

    div_datapath #(.DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (go),
        .step_i    (dvoe_o),
        .ndiv_i    (ndiv),
        .dividend_i(dividend_i),
        .pair_o    (pair_o),
        .rem_o     (rem)
    );

    div_flags #(.DW(DW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .dvsr_zero_i(dvsr_zero),
        .rmoe_i     (rmoe_o),
        .rem_i      (rem),
        .ovf_o      (ovf_o),
        .zero_o     (zero_o)
    );

    // Shared result output: remainder in its strobe cycle, pair otherwise.
    always_comb begin
        sel      = rmoe_o ? RES_REM : RES_PAIR;
        result_o = (sel == RES_REM) ? {{(QW-DW){1'b0}}, rem} : pair_o;
    end
endmodule

// File: rtl/div_chk.sv
// Protocol checker for restoring_divider, bound to every instance.
module div_chk #(
    parameter int unsigned DW = 8,
    parameter int unsigned QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [DW-1:0] acc_i,
    input logic [QW-1:0] pair_o,
    input logic [QW-1:0] result_o,
    input logic          dvoe_o,
    input logic          rmoe_o,
    input logic          ovf_o,
    input logic          zero_o
);
    localparam int unsigned RW = $clog2(QW) + 2;
    logic [RW-1:0] run_q;
    logic          idle;

    assign idle = ~dvoe_o & ~rmoe_o;

    // Length of the current quotient-strobe run.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (dvoe_o) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    // R2
    go_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle && acc_i != '0) |=> (dvoe_o && !ovf_o));
    // R3
    zero_dvsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle && acc_i == '0) |=> (ovf_o && !dvoe_o && !rmoe_o));
    // R4
    dvoe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dvoe_o) |-> (run_q == RW'(QW)));
    // R5
    rmoe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dvoe_o) |-> rmoe_o);
    // R5
    rmoe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmoe_o |=> !rmoe_o);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dvoe_o && rmoe_o));
    // R7
    rem_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmoe_o |-> (result_o[QW-1:DW] == '0));
    // R8
    pair_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rmoe_o |-> (result_o == pair_o));
    // R9
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rmoe_o |=> $stable(zero_o));
    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && rmoe_o) |=> !dvoe_o);
    // R11
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && idle) |=> $stable(ovf_o));
endmodule

bind restoring_divider div_chk #(.DW(DW), .QW(QW)) u_div_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .acc_i   (acc_i),
    .pair_o  (pair_o),
    .result_o(result_o),
    .dvoe_o  (dvoe_o),
    .rmoe_o  (rmoe_o),
    .ovf_o   (ovf_o),
    .zero_o  (zero_o)
);

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  acc = '0;
    logic [15:0] dividend = '0;
    logic [15:0] pair, result;
    logic        dvoe, rmoe, ovf, zero;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    restoring_divider u_restoring_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start), .acc_i(acc),
        .dividend_i(dividend), .pair_o(pair), .result_o(result),
        .dvoe_o(dvoe), .rmoe_o(rmoe), .ovf_o(ovf), .zero_o(zero)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One division; optionally pokes start mid-run and in the remainder cycle (R10).
    task automatic run_div(input logic [15:0] dvd, input logic [7:0] dvs, input bit poke);
        logic [15:0] q;
        logic [7:0]  r;
        int n;
        q = dvd / {8'h00, dvs};
        r = 8'(dvd % {8'h00, dvs});
        start = 1'b1; acc = dvs; dividend = dvd;
        @(negedge clk);
        start = 1'b0;
        chk(dvoe == 1'b1, "R2 dvoe", 32'(dvoe), 1);
        chk(ovf == 1'b0, "R2 ovf", 32'(ovf), 0);
        chk(pair == dvd, "R2 pair load", 32'(pair), 32'(dvd));
        chk(result == pair, "R8 result", 32'(result), 32'(pair));
        n = 1;
        while (1) begin
            if (poke && n == 5) begin
                start = 1'b1; acc = 8'h00; dividend = ~dvd;
            end
            @(negedge clk);
            start = 1'b0; acc = dvs; dividend = dvd;
            if (!dvoe) break;
            n++;
        end
        chk(n == 16, "R4 dvoe length", 32'(n), 16);
        chk(rmoe == 1'b1, "R5 rmoe", 32'(rmoe), 1);
        chk(pair == q, "R6 quotient", 32'(pair), 32'(q));
        chk(result == {8'h00, r}, "R7 remainder", 32'(result), 32'(r));
        chk(ovf == 1'b0, "R11 ovf", 32'(ovf), 0);
        if (poke) begin
            start = 1'b1; acc = 8'h03; dividend = 16'h1234;
        end
        @(negedge clk);
        start = 1'b0;
        chk(rmoe == 1'b0, "R5 rmoe width", 32'(rmoe), 0);
        chk(zero == (r == 8'h00), "R9 zero flag", 32'(zero), 32'(r == 8'h00));
        if (poke) begin
            chk(dvoe == 1'b0, "R10 ignored start", 32'(dvoe), 0);
            chk(pair == q, "R10 pair kept", 32'(pair), 32'(q));
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [15:0] keep_pair;
        logic        keep_zero;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dvoe == 0 && rmoe == 0, "R1 strobes", {30'd0, dvoe, rmoe}, 0);
        chk(ovf == 0 && zero == 0, "R1 flags", {30'd0, ovf, zero}, 0);
        chk(pair == 0 && result == 0, "R1 pair/result", 32'(pair), 0);

        // R3 zero divisor: overflow, no strobes, state kept
        run_div(16'd1000, 8'd7, 1'b0);
        keep_pair = pair; keep_zero = zero;
        start = 1'b1; acc = 8'h00; dividend = 16'hBEEF;
        @(negedge clk);
        start = 1'b0;
        chk(ovf == 1'b1, "R3 ovf set", 32'(ovf), 1);
        chk(dvoe == 1'b0, "R3 no dvoe", 32'(dvoe), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(dvoe == 0 && rmoe == 0, "R3 no strobes", {30'd0, dvoe, rmoe}, 0);
        end
        chk(pair == keep_pair, "R3 pair kept", 32'(pair), 32'(keep_pair));
        chk(zero == keep_zero, "R3 zero kept", 32'(zero), 32'(keep_zero));
        chk(ovf == 1'b1, "R11 ovf held", 32'(ovf), 1);

        // R10 pokes with R2 clearing the overflow
        run_div(16'hFFFF, 8'hFF, 1'b1);
        run_div(16'd5, 8'd200, 1'b1);

        // R6/R7 sweep: every divisor against sixteen dividends
        for (int d = 1; d < 256; d++) begin
            for (int k = 0; k < 16; k++) begin
                logic [15:0] dv;
                if (k == 0) dv = 16'h0000;
                else if (k == 1) dv = 16'hFFFF;
                else if (k == 2) dv = 16'h8000;
                else if (k == 3) dv = 16'(d);
                else begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    dv = lfsr;
                end
                run_div(dv, 8'(d), 1'b0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule